// File: doc/BRIEF.md
# Debug Link Write-Command Decoder

This block sits behind the byte deserialiser of a serial debug link. It turns the incoming byte stream into single write operations. The first byte of a command is an opcode. From its bit fields the decoder works out how many address and data bytes follow. It collects them, most significant byte first, and then raises exactly one request towards one of four targets:

- a memory write port;
- a processor register write port;
- a debug-control byte port;
- a resume strobe.

Memory and register targets return a completion strobe. The debug-control byte and the resume strobe are taken to complete in the cycle they are raised.

On completion the decoder can give two further outputs. When acknowledge mode is on, it produces a one-cycle acknowledge pulse for the serial layer. For the with-status memory variant, it also produces a one-cycle status byte. Only one command is handled at a time. Bytes that arrive while a request is outstanding are dropped and flagged. Size code 3 and unrecognised opcodes never reach a target.

Top module: `dbg_wcmd_dec`

## Requirements
- R1: Opcode 0x10+4*s, with size code s in {0,1,2}, is a memory write. It takes 3 address bytes, then 1, 2 or 4 data bytes (for s = 0, 1, 2), each field MSB first. After the last byte, mem_req is high with mem_addr, mem_size=s and mem_wdata right-aligned. These stay held and stable until the cycle in which mem_done is high.
- R2: Opcode 0x11+4*s is the same memory write with a status report. In the cycle after mem_done, stat_vld is high for one cycle. stat_byte has bit 7 = 1, bit 6 = the mem_err value seen with mem_done, and bits 5:0 = 0.
- R3: An opcode whose upper nibble is 0x4, 0x8 or 0xC is a register write. The low nibble is the register index. The opcode is followed by 4 data bytes, MSB first. reg_req is then held high with reg_class = opcode bits 7:6 (01, 10, 11), reg_idx and reg_wdata, until reg_done.
- R4: Opcodes 0x0D, 0x0E and 0x0F are each followed by one byte. They raise dcr_req for exactly one cycle, with dcr_sel = 0, 1 or 2 respectively and dcr_wbyte = that byte.
- R5: Opcode 0x0C raises resume_req for one cycle when cpu_halted is high as the opcode is taken. Otherwise it has no effect: no request and no acknowledge.
- R6: When ack_en is high in the cycle an operation completes, ack_pulse is high for exactly the following cycle. When ack_en is low, no pulse is produced.
- R7: A memory opcode with size code 3 (0x1C or 0x1D) pulses err_size for one cycle in the cycle after the opcode. It issues no request, and the next byte is taken as a new opcode.
- R8: Any other opcode (for example 0x00) issues no request, no acknowledge and no error. The next byte is taken as a new opcode.
- R9: A byte that arrives while a request is outstanding pulses err_overrun in the next cycle. The byte is discarded, and the outstanding request's fields do not change.
- R10: After reset all requests, stat_vld, ack_pulse and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| ack_en | input | 1 | Acknowledge mode enable |
| cpu_halted | input | 1 | Processor is halted |
| mem_req | output | 1 | Memory write request, held until mem_done |
| mem_addr | output | 24 | Memory byte address |
| mem_size | output | 2 | Size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_done | input | 1 | Memory write completion |
| mem_err | input | 1 | Bus error, valid with mem_done |
| reg_req | output | 1 | Register write request, held until reg_done |
| reg_class | output | 2 | Register class (opcode bits 7:6) |
| reg_idx | output | 4 | Register index |
| reg_wdata | output | 32 | Register write data |
| reg_done | input | 1 | Register write completion |
| dcr_req | output | 1 | One-cycle debug-control byte write |
| dcr_sel | output | 2 | Debug-control register select |
| dcr_wbyte | output | 8 | Byte for the selected register's top byte |
| resume_req | output | 1 | One-cycle resume strobe |
| stat_vld | output | 1 | Status byte valid for one cycle |
| stat_byte | output | 8 | Status byte (bit 7 done, bit 6 bus error) |
| ack_pulse | output | 1 | One-cycle acknowledge request |
| err_size | output | 1 | Illegal size code seen |
| err_overrun | output | 1 | Byte arrived while busy |

## Verification
The assertions assume that mem_done and reg_done arrive only while the matching request is high. They also assume that mem_err is meaningful only alongside mem_done. The bench's target models keep to this: they wait until they see the request before raising a completion strobe for one cycle. Bytes arrive as single-cycle rx_vld pulses driven between clock edges. A byte is sent while a request is outstanding only in the dedicated overrun scenario.

// File: rtl/dbg_wcmd_pkg.sv
package dbg_wcmd_pkg;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHIFT_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W   = 3;

  typedef enum logic [2:0] {K_NONE, K_MEM, K_REG, K_DCR, K_RES, K_BAD} kind_t;
  typedef enum logic [1:0] {S_IDLE, S_COLL, S_WAIT} state_t;

  typedef struct packed {
    kind_t            kind;
    logic             with_stat;
    logic [1:0]       sz;
    logic [1:0]       cls;
    logic [3:0]       idx;
    logic [CNT_W-1:0] nbytes;
  } dec_t;
endpackage

// File: rtl/dbg_wcmd_opdec.sv
module dbg_wcmd_opdec
  import dbg_wcmd_pkg::*;
#(
  parameter logic [7:0] RESUME_OP = 8'h0C
) (
  input  logic [7:0] op,
  output dec_t       dec
);
  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    if (op[7:4] == 4'h1 && !op[1]) begin
      dec.sz        = op[3:2];
      dec.with_stat = op[0];
      if (op[3:2] == 2'd3) begin
        dec.kind = K_BAD;
      end else begin
        dec.kind   = K_MEM;
        dec.nbytes = CNT_W'(3) + (CNT_W'(1) << op[3:2]);
      end
    end else if (op[5:4] == 2'b00 && op[7:6] != 2'b00) begin
      dec.kind   = K_REG;
      dec.cls    = op[7:6];
      dec.idx    = op[3:0];
      dec.nbytes = CNT_W'(4);
    end else if (op[7:2] == 6'b000011 && op[1:0] != 2'b00) begin
      dec.kind   = K_DCR;
      dec.idx    = {2'b00, 2'(op[1:0] - 2'd1)};
      dec.nbytes = CNT_W'(1);
    end else if (op == RESUME_OP) begin
      dec.kind = K_RES;
    end
  end
endmodule

// File: rtl/dbg_wcmd_shift.sv
module dbg_wcmd_shift #(
  parameter int unsigned W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic [7:0]   din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)           q_n = '0;
    else if (shift_en) q_n = {q[W-9:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr || shift_en)  q <= q_n;
  end
endmodule

// File: rtl/dbg_wcmd_dec.sv
module dbg_wcmd_dec
  import dbg_wcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic              ack_en,
  input  logic              cpu_halted,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_done,
  input  logic              mem_err,
  output logic              reg_req,
  output logic [1:0]        reg_class,
  output logic [3:0]        reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_done,
  output logic              dcr_req,
  output logic [1:0]        dcr_sel,
  output logic [7:0]        dcr_wbyte,
  output logic              resume_req,
  output logic              stat_vld,
  output logic [7:0]        stat_byte,
  output logic              ack_pulse,
  output logic              err_size,
  output logic              err_overrun
);
  state_t             st_q, st_n;
  dec_t               cmd_q, cmd_n, dec;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [SHIFT_W-1:0] sh;
  logic               sh_clr, sh_en, done;
  logic               ack_n, statv_n, esz_n, eovr_n;
  logic [7:0]         statb_n;

  dbg_wcmd_opdec u_opdec (.op(rx_byte), .dec(dec));

  dbg_wcmd_shift #(.W(SHIFT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
    .din(rx_byte), .q(sh)
  );

  always_comb begin
    case (cmd_q.kind)
      K_MEM:   done = mem_done;
      K_REG:   done = reg_done;
      default: done = 1'b1;
    endcase
  end

  always_comb begin
    st_n    = st_q;
    cmd_n   = cmd_q;
    cnt_n   = cnt_q;
    sh_clr  = 1'b0;
    sh_en   = 1'b0;
    ack_n   = 1'b0;
    statv_n = 1'b0;
    statb_n = stat_byte;
    esz_n   = 1'b0;
    eovr_n  = 1'b0;
    case (st_q)
      S_IDLE: if (rx_vld) begin
        sh_clr = 1'b1;
        case (dec.kind)
          K_MEM, K_REG, K_DCR: begin
            cmd_n = dec;
            cnt_n = dec.nbytes;
            st_n  = S_COLL;
          end
          K_RES: if (cpu_halted) begin
            cmd_n = dec;
            st_n  = S_WAIT;
          end
          K_BAD:   esz_n = 1'b1;
          default: ;
        endcase
      end
      S_COLL: if (rx_vld) begin
        sh_en = 1'b1;
        cnt_n = cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) st_n = S_WAIT;
      end
      S_WAIT: begin
        eovr_n = rx_vld;
        if (done) begin
          st_n  = S_IDLE;
          ack_n = ack_en;
          if (cmd_q.kind == K_MEM && cmd_q.with_stat) begin
            statv_n = 1'b1;
            statb_n = {1'b1, mem_err, 6'b000000};
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cmd_q       <= '0;
      cnt_q       <= '0;
      ack_pulse   <= 1'b0;
      stat_vld    <= 1'b0;
      stat_byte   <= '0;
      err_size    <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      st_q        <= st_n;
      cmd_q       <= cmd_n;
      cnt_q       <= cnt_n;
      ack_pulse   <= ack_n;
      stat_vld    <= statv_n;
      stat_byte   <= statb_n;
      err_size    <= esz_n;
      err_overrun <= eovr_n;
    end
  end

  assign mem_req    = (st_q == S_WAIT) && (cmd_q.kind == K_MEM);
  assign reg_req    = (st_q == S_WAIT) && (cmd_q.kind == K_REG);
  assign dcr_req    = (st_q == S_WAIT) && (cmd_q.kind == K_DCR);
  assign resume_req = (st_q == S_WAIT) && (cmd_q.kind == K_RES);
  assign mem_size   = cmd_q.sz;

  always_comb begin
    case (cmd_q.sz)
      2'd0: begin
        mem_addr  = sh[ADDR_W+7:8];
        mem_wdata = {{(DATA_W-8){1'b0}}, sh[7:0]};
      end
      2'd1: begin
        mem_addr  = sh[ADDR_W+15:16];
        mem_wdata = {{(DATA_W-16){1'b0}}, sh[15:0]};
      end
      default: begin
        mem_addr  = sh[ADDR_W+DATA_W-1:DATA_W];
        mem_wdata = sh[DATA_W-1:0];
      end
    endcase
  end

  assign reg_class = cmd_q.cls;
  assign reg_idx   = cmd_q.idx;
  assign reg_wdata = sh[DATA_W-1:0];
  assign dcr_sel   = cmd_q.idx[1:0];
  assign dcr_wbyte = sh[7:0];

  // R1
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_done) |=> (reg_req && $stable(reg_wdata) && $stable(reg_idx)));
  // R4
  dcr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dcr_req |=> !dcr_req);
  // R5
  resume_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_req) |-> $past(cpu_halted));
  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |=> !ack_pulse);
  // R2
  stat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld);
  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, reg_req, dcr_req, resume_req}));
  // R9
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rx_vld && !mem_done) |=> $stable(mem_addr) && $stable(mem_wdata));
endmodule

// File: tb/dbg_wcmd_dec_tb.sv
`timescale 1ns/1ps
module dbg_wcmd_dec_tb;
  logic clk, rst_n, rx_vld, ack_en, cpu_halted;
  logic [7:0] rx_byte;
  logic mem_req, mem_done, mem_err, reg_req, reg_done, dcr_req, resume_req;
  logic [23:0] mem_addr;
  logic [1:0] mem_size, reg_class, dcr_sel;
  logic [31:0] mem_wdata, reg_wdata;
  logic [3:0] reg_idx;
  logic [7:0] dcr_wbyte, stat_byte;
  logic stat_vld, ack_pulse, err_size, err_overrun;
  int vecs = 0;
  int errs = 0;

  dbg_wcmd_dec u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_vld = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_vld = 1'b0;
  endtask

  task automatic wait_for(input int which);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if ((which == 0 && mem_req) || (which == 1 && reg_req)) break;
    end
  endtask

  task automatic t_mem(input int sz, input logic st, input logic [23:0] a,
                       input logic [31:0] d, input logic e, input logic ae);
    int nb;
    nb = 1 << sz;
    ack_en = ae;
    send(8'(8'h10 + 4 * sz + int'(st)));
    for (int i = 2; i >= 0; i--) send(a[8*i +: 8]);
    for (int i = nb - 1; i >= 0; i--) send(d[8*i +: 8]);
    wait_for(0);
    chk("R1 mem_req", 32'(mem_req), 32'd1);
    chk("R1 mem_addr", 32'(mem_addr), 32'(a));
    chk("R1 mem_size", 32'(mem_size), 32'(sz));
    chk("R1 mem_wdata", mem_wdata, d);
    mem_done = 1'b1; mem_err = e;
    @(negedge clk);
    mem_done = 1'b0; mem_err = 1'b0;
    chk("R1 req dropped", 32'(mem_req), 32'd0);
    chk("R6 ack", 32'(ack_pulse), 32'(ae));
    chk("R2 stat_vld", 32'(stat_vld), 32'(st));
    if (st) chk("R2 stat_byte", 32'(stat_byte), 32'({1'b1, e, 6'b0}));
    @(negedge clk);
    chk("R6 ack single", 32'(ack_pulse), 32'd0);
    chk("R2 stat single", 32'(stat_vld), 32'd0);
  endtask

  task automatic t_reg(input logic [1:0] cls, input logic [3:0] idx, input logic [31:0] d);
    ack_en = 1'b1;
    send({cls, 2'b00, idx});
    for (int i = 3; i >= 0; i--) send(d[8*i +: 8]);
    wait_for(1);
    repeat (3) @(negedge clk);
    chk("R3 reg_req held", 32'(reg_req), 32'd1);
    chk("R3 reg_class", 32'(reg_class), 32'(cls));
    chk("R3 reg_idx", 32'(reg_idx), 32'(idx));
    chk("R3 reg_wdata", reg_wdata, d);
    chk("R6 no ack while busy", 32'(ack_pulse), 32'd0);
    reg_done = 1'b1;
    @(negedge clk);
    reg_done = 1'b0;
    chk("R3 reg_req dropped", 32'(reg_req), 32'd0);
    chk("R6 ack reg", 32'(ack_pulse), 32'd1);
  endtask

  task automatic t_dcr(input int k, input logic [7:0] b, input logic ae);
    ack_en = ae;
    send(8'(8'h0D + k));
    send(b);
    @(negedge clk);
    chk("R4 dcr_req", 32'(dcr_req), 32'd1);
    chk("R4 dcr_sel", 32'(dcr_sel), 32'(k));
    chk("R4 dcr_wbyte", 32'(dcr_wbyte), 32'(b));
    @(negedge clk);
    chk("R4 dcr single", 32'(dcr_req), 32'd0);
    chk("R6 ack dcr", 32'(ack_pulse), 32'(ae));
  endtask

  task automatic t_resume(input logic h);
    ack_en = 1'b1; cpu_halted = h;
    send(8'h0C);
    @(negedge clk);
    chk("R5 resume_req", 32'(resume_req), 32'(h));
    @(negedge clk);
    chk("R5 resume single", 32'(resume_req), 32'd0);
    chk("R5 ack on resume", 32'(ack_pulse), 32'(h));
    cpu_halted = 1'b0;
  endtask

  task automatic t_badsize(input logic st);
    send(st ? 8'h1D : 8'h1C);
    @(negedge clk);
    chk("R7 err_size", 32'(err_size), 32'd1);
    chk("R7 no mem_req", 32'(mem_req), 32'd0);
    @(negedge clk);
    chk("R7 err single", 32'(err_size), 32'd0);
    t_dcr(2, 8'h3C, 1'b1);
  endtask

  task automatic t_unknown();
    ack_en = 1'b1;
    send(8'h00);
    send(8'h12);
    @(negedge clk);
    chk("R8 no req", 32'({mem_req, reg_req, dcr_req, resume_req}), 32'd0);
    chk("R8 no ack", 32'(ack_pulse), 32'd0);
    chk("R8 no err", 32'({err_size, err_overrun}), 32'd0);
    t_dcr(0, 8'h81, 1'b1);
  endtask

  task automatic t_overrun();
    ack_en = 1'b1;
    send(8'h14);
    send(8'h12); send(8'h34); send(8'h56);
    send(8'hBE); send(8'hEF);
    wait_for(0);
    send(8'hAA);
    @(negedge clk);
    chk("R9 err_overrun", 32'(err_overrun), 32'd1);
    chk("R9 addr kept", 32'(mem_addr), 32'h123456);
    chk("R9 data kept", mem_wdata, 32'h0000BEEF);
    chk("R9 still busy", 32'(mem_req), 32'd1);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    chk("R9 ack after", 32'(ack_pulse), 32'd1);
    chk("R9 err single", 32'(err_overrun), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_vld = 1'b0; rx_byte = '0; ack_en = 1'b0; cpu_halted = 1'b0;
    mem_done = 1'b0; mem_err = 1'b0; reg_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reqs", 32'({mem_req, reg_req, dcr_req, resume_req}), 32'd0);
    chk("R10 pulses", 32'({stat_vld, ack_pulse, err_size, err_overrun}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_mem(0, 1'b0, 24'hA1B2C3, 32'h0000005A, 1'b0, 1'b1);
    t_mem(1, 1'b1, 24'h000100, 32'h0000C0DE, 1'b1, 1'b1);
    t_mem(2, 1'b1, 24'hFFFFFC, 32'hDEADBEEF, 1'b0, 1'b0);
    t_mem(2, 1'b0, 24'h123456, 32'h01020304, 1'b0, 1'b0);
    t_reg(2'b01, 4'h3, 32'h11223344);
    t_reg(2'b10, 4'hF, 32'hCAFEF00D);
    t_reg(2'b11, 4'h0, 32'h80000001);
    t_dcr(0, 8'h5A, 1'b1);
    t_dcr(1, 8'hA5, 1'b0);
    t_dcr(2, 8'hFF, 1'b1);
    t_resume(1'b1);
    t_resume(1'b0);
    t_badsize(1'b0);
    t_badsize(1'b1);
    t_unknown();
    t_overrun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule